// File: doc/BRIEF.md
# Lane-Steered Pass-Through Holding Register

This block is a 32-bit holding register that sits between a host-side transaction engine and a narrower (or equally wide) local bus. The host side opens a transaction with a one-cycle load pulse. The pulse carries the direction, an active-low mask of the bytes the host cares about, and (for host writes) the data. The local side then moves those bytes one lane group at a time over an 8-, 16- or 32-bit data path. The block steers each local byte to or from the correct register byte, using the local byte enables, the width code and one address bit.

While a transaction is open, the block keeps an active-low pending mask with one bit per register byte. Each serviced byte sets its bit high. In a drain transaction (host writes, local side reads), the local reads service the bytes. In a fill transaction (host reads, local side writes), the local writes service them. Once all four bits are high, a registered completion flag rises, and the local logic uses it to finish the transfer.

The control is a four-state machine:
- `ST_IDLE`: after reset.
- `ST_DRAIN`: host-write transaction open.
- `ST_FILL`: host-read transaction open.
- `ST_DONE`: every byte serviced.

Its transitions are:
- load → `ST_DRAIN` or `ST_FILL`, from any state, chosen by the direction bit.
- `ST_DRAIN`/`ST_FILL` → `ST_DONE` once the pending mask is all ones.
- `ST_IDLE` and `ST_DONE` hold until the next load.

Top module: `lane_steer_hold`

## Requirements
- R1: After reset the pending mask reads 4'b1111, the completion flag is 0 and the host read data is 0.
- R2: A host load pulse loads the pending mask from the requested mask and the register from the host write data, and clears the completion flag in that same edge. A load takes precedence over any local access in that cycle.
- R3: Width code 2'b00 (8-bit): each enabled register byte n (loc_be_n[n]=0) takes loc_din[7:0].
- R4: Width code 2'b01 (16-bit): only bytes in the half chosen by loc_a1 are enabled (loc_a1=0: bytes 0–1, loc_a1=1: bytes 2–3). Even bytes use data bits [7:0] and odd bytes use bits [15:8].
- R5: Width code 2'b10, and the reserved code 2'b11, is 32-bit mode: byte n maps to data bits [8n+7:8n] with no shift.
- R6: On a local read (loc_sel=1, loc_rd=1, loc_wr=0), loc_dout is driven combinationally as follows, and otherwise it is 0:
  - 8-bit mode: the lowest-indexed enabled byte on bits [7:0].
  - 16-bit mode: the enabled bytes of the chosen half on bits [15:0].
  - 32-bit mode: the enabled bytes in place.
  - Every lane not driven by an enabled byte is 0.
- R7: In a drain transaction, a local read sets the pending bit of each enabled byte high.
- R8: In a fill transaction, a local write stores each enabled byte and sets its pending bit high.
- R9: The completion flag rises one clock after the clock edge that leaves all pending bits high. It stays high until the next load.
- R10: These accesses change neither the register nor the pending mask:
  - a cycle with loc_sel=0;
  - a cycle with no enabled byte after width masking;
  - a cycle with both strobes set;
  - a strobe of the wrong direction;
  - any local access outside an open transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_load | input | 1 | One-cycle pulse opening a new transaction |
| host_dir_rd | input | 1 | 1 = host read (fill), 0 = host write (drain) |
| host_req_be_n | input | 4 | Active-low bytes requested by the host |
| host_wdata | input | 32 | Data loaded with the pulse |
| host_rdata | output | 32 | Current register contents |
| loc_sel | input | 1 | Local select |
| loc_rd | input | 1 | Local read strobe |
| loc_wr | input | 1 | Local write strobe |
| loc_be_n | input | 4 | Local active-low byte enables |
| loc_a1 | input | 1 | Half select for 16-bit mode |
| loc_width | input | 2 | 00 = 8-bit, 01 = 16-bit, 1x = 32-bit |
| loc_din | input | 32 | Local write data |
| loc_dout | output | 32 | Local read data |
| pend_n | output | 4 | Active-low pending byte mask |
| done | output | 1 | Registered completion flag |

## Verification
The assertions rely on a few assumptions about the inputs:
- host_load is a single-cycle pulse that alone may lower pending bits.
- loc_width is steady during a local access cycle.
- Every input is stable around the rising edge.

The stimulus drives all inputs on the falling edge. It mixes directed sequences for each width, half and direction with a long randomized run. That run issues loads at random moments, including cycles in which a load meets a local strobe.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_FILL  = 2'd2,
        ST_DONE  = 2'd3
    } hold_state_e;

    typedef enum logic [1:0] {
        LW_8   = 2'd0,
        LW_16  = 2'd1,
        LW_32  = 2'd2,
        LW_32X = 2'd3
    } lane_width_e;

    localparam int LANE_W = 8;

endpackage

// File: rtl/lane_enable_map.sv
module lane_enable_map
    import lane_steer_pkg::*;
#(
    parameter int BYTES = 4
) (
    input  logic [1:0]       width,
    input  logic             a1,
    input  logic [BYTES-1:0] be_n,
    output logic [BYTES-1:0] en
);
    // Turns local byte enables into register byte enables.
    for (genvar k = 0; k < BYTES; k++) begin : g_lane
        localparam logic HALF = 1'((k / 2) % 2);
        always_comb begin
            unique case (width)
                LW_8:    en[k] = ~be_n[k];
                LW_16:   en[k] = ~be_n[k] & (a1 == HALF);
                default: en[k] = ~be_n[k];
            endcase
        end
    end
endmodule

// File: rtl/lane_write_steer.sv
module lane_write_steer
    import lane_steer_pkg::*;
#(
    parameter int BYTES = 4,
    localparam int DW = BYTES * LANE_W
) (
    input  logic [1:0]    width,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] wbytes
);
    // Presents, for every register byte, the local lane that feeds it.
    for (genvar k = 0; k < BYTES; k++) begin : g_byte
        localparam int LOW16 = (k % 2) * LANE_W;
        localparam int DIRECT = k * LANE_W;
        always_comb begin
            unique case (width)
                LW_8:    wbytes[DIRECT +: LANE_W] = din[LANE_W-1:0];
                LW_16:   wbytes[DIRECT +: LANE_W] = din[LOW16 +: LANE_W];
                default: wbytes[DIRECT +: LANE_W] = din[DIRECT +: LANE_W];
            endcase
        end
    end
endmodule

// File: rtl/lane_read_steer.sv
module lane_read_steer
    import lane_steer_pkg::*;
#(
    parameter int BYTES = 4,
    localparam int DW = BYTES * LANE_W,
    localparam int SELW = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic [1:0]       width,
    input  logic             active,
    input  logic [BYTES-1:0] en,
    input  logic [DW-1:0]    regdata,
    output logic [DW-1:0]    dout
);
    logic [SELW-1:0] pick;

    // Lowest enabled byte wins the single 8-bit lane.
    always_comb begin
        pick = '0;
        for (int k = BYTES - 1; k >= 0; k--) begin
            if (en[k]) pick = SELW'(k);
        end
    end

    always_comb begin
        dout = '0;
        if (active) begin
            unique case (width)
                LW_8: begin
                    if (|en) dout[LANE_W-1:0] = regdata[pick*LANE_W +: LANE_W];
                end
                LW_16: begin
                    for (int k = 0; k < BYTES; k++) begin
                        if (en[k])
                            dout[(k % 2)*LANE_W +: LANE_W] =
                                dout[(k % 2)*LANE_W +: LANE_W] | regdata[k*LANE_W +: LANE_W];
                    end
                end
                default: begin
                    for (int k = 0; k < BYTES; k++) begin
                        if (en[k]) dout[k*LANE_W +: LANE_W] = regdata[k*LANE_W +: LANE_W];
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/lane_steer_hold.sv
module lane_steer_hold
    import lane_steer_pkg::*;
#(
    parameter int BYTES = 4,
    localparam int DW = BYTES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_load,
    input  logic             host_dir_rd,
    input  logic [BYTES-1:0] host_req_be_n,
    input  logic [DW-1:0]    host_wdata,
    output logic [DW-1:0]    host_rdata,
    input  logic             loc_sel,
    input  logic             loc_rd,
    input  logic             loc_wr,
    input  logic [BYTES-1:0] loc_be_n,
    input  logic             loc_a1,
    input  logic [1:0]       loc_width,
    input  logic [DW-1:0]    loc_din,
    output logic [DW-1:0]    loc_dout,
    output logic [BYTES-1:0] pend_n,
    output logic             done
);
    hold_state_e      state_q, state_d;
    logic [DW-1:0]    data_q;
    logic [BYTES-1:0] pend_q;
    logic [BYTES-1:0] en;
    logic [DW-1:0]    wbytes;
    logic             rd_act, wr_act, all_clr;
    logic             fill_go, drain_go;

    assign rd_act   = loc_sel & loc_rd & ~loc_wr;
    assign wr_act   = loc_sel & loc_wr & ~loc_rd;
    assign all_clr  = &pend_q;
    assign fill_go  = (state_q == ST_FILL)  & ~all_clr & wr_act;
    assign drain_go = (state_q == ST_DRAIN) & ~all_clr & rd_act;

    lane_enable_map #(.BYTES(BYTES)) u_map (
        .width (loc_width),
        .a1    (loc_a1),
        .be_n  (loc_be_n),
        .en    (en)
    );

    lane_write_steer #(.BYTES(BYTES)) u_wr (
        .width  (loc_width),
        .din    (loc_din),
        .wbytes (wbytes)
    );

    lane_read_steer #(.BYTES(BYTES)) u_rd (
        .width   (loc_width),
        .active  (rd_act),
        .en      (en),
        .regdata (data_q),
        .dout    (loc_dout)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (host_load) begin
            state_d = host_dir_rd ? ST_FILL : ST_DRAIN;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_DRAIN: if (all_clr) state_d = ST_DONE;
                ST_FILL:  if (all_clr) state_d = ST_DONE;
                ST_DONE:  state_d = ST_DONE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // Data and pending mask
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            pend_q <= '1;
        end else if (host_load) begin
            data_q <= host_wdata;
            pend_q <= host_req_be_n;
        end else begin
            for (int k = 0; k < BYTES; k++) begin
                if (fill_go && en[k]) begin
                    data_q[k*LANE_W +: LANE_W] <= wbytes[k*LANE_W +: LANE_W];
                    pend_q[k] <= 1'b1;
                end
                if (drain_go && en[k]) pend_q[k] <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        host_rdata = data_q;
        pend_n     = pend_q;
        done       = (state_q == ST_DONE);
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        host_load |=> (pend_n == $past(host_req_be_n)) && !done && (host_rdata == $past(host_wdata)));

    assert_pend_rises_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !host_load |=> ((pend_n & $past(pend_n)) == $past(pend_n)));

    assert_done_after_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(&pend_n));

    assert_done_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !host_load) |=> done);

    assert_done_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (&pend_n));

    assert_unselected_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!loc_sel && !host_load) |=> ($stable(pend_n) && $stable(host_rdata)));

    assert_narrow_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_width == LW_8) |-> (loc_dout[DW-1:LANE_W] == '0));

endmodule

// File: tb/sim_lane_steer_hold.sv
module sim_lane_steer_hold;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_load = 0, host_dir_rd = 0;
    logic [3:0]  host_req_be_n = 4'hF;
    logic [31:0] host_wdata = 0;
    logic [31:0] host_rdata;
    logic        loc_sel = 0, loc_rd = 0, loc_wr = 0, loc_a1 = 0;
    logic [3:0]  loc_be_n = 4'hF;
    logic [1:0]  loc_width = 0;
    logic [31:0] loc_din = 0;
    logic [31:0] loc_dout;
    logic [3:0]  pend_n;
    logic        done;

    int vectors = 0;
    int errors = 0;

    // reference model state: 0 idle, 1 drain, 2 fill, 3 done
    int         m_state = 0;
    logic [7:0] m_b[4] = '{default: 8'h00};
    logic [3:0] m_pend = 4'hF;

    always #5 clk = ~clk;

    lane_steer_hold u0 (
        .clk(clk), .rst_n(rst_n), .host_load(host_load), .host_dir_rd(host_dir_rd),
        .host_req_be_n(host_req_be_n), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .loc_sel(loc_sel), .loc_rd(loc_rd), .loc_wr(loc_wr), .loc_be_n(loc_be_n),
        .loc_a1(loc_a1), .loc_width(loc_width), .loc_din(loc_din), .loc_dout(loc_dout),
        .pend_n(pend_n), .done(done)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] m_en();
        logic [3:0] e;
        for (int k = 0; k < 4; k++) begin
            if (loc_width == 2'd0)      e[k] = !loc_be_n[k];
            else if (loc_width == 2'd1) e[k] = !loc_be_n[k] && (((k / 2) % 2) == int'(loc_a1));
            else                        e[k] = !loc_be_n[k];
        end
        return e;
    endfunction

    function automatic logic [31:0] m_dout();
        logic [31:0] d = 0;
        logic [3:0] e = m_en();
        if (!(loc_sel && loc_rd && !loc_wr)) return 0;
        if (loc_width == 2'd0) begin
            for (int k = 0; k < 4; k++) if (e[k]) begin d[7:0] = m_b[k]; break; end
        end else if (loc_width == 2'd1) begin
            for (int k = 0; k < 4; k++) if (e[k]) d[8*(k%2) +: 8] = m_b[k];
        end else begin
            for (int k = 0; k < 4; k++) if (e[k]) d[8*k +: 8] = m_b[k];
        end
        return d;
    endfunction

    task automatic m_step();
        logic [3:0] e = m_en();
        bit allset = (m_pend == 4'hF);
        bit rda = loc_sel && loc_rd && !loc_wr;
        bit wra = loc_sel && loc_wr && !loc_rd;
        if (host_load) begin
            for (int k = 0; k < 4; k++) m_b[k] = host_wdata[8*k +: 8];
            m_pend = host_req_be_n;
            m_state = host_dir_rd ? 2 : 1;
        end else if ((m_state == 1 || m_state == 2) && allset) begin
            m_state = 3;
        end else if (m_state == 2 && wra) begin
            for (int k = 0; k < 4; k++) if (e[k]) begin
                if (loc_width == 2'd0)      m_b[k] = loc_din[7:0];
                else if (loc_width == 2'd1) m_b[k] = loc_din[8*(k%2) +: 8];
                else                        m_b[k] = loc_din[8*k +: 8];
                m_pend[k] = 1'b1;
            end
        end else if (m_state == 1 && rda) begin
            m_pend = m_pend | e;
        end
    endtask

    function automatic logic [31:0] m_word();
        return {m_b[3], m_b[2], m_b[1], m_b[0]};
    endfunction

    // One clock: drive at negedge, check combinational read, clock, check registers.
    task automatic cyc(string req, bit ld, bit dir, logic [3:0] rq, logic [31:0] wd,
                       bit sel, bit rd, bit wr, logic [3:0] be, bit a1, logic [1:0] w,
                       logic [31:0] din);
        host_load = ld; host_dir_rd = dir; host_req_be_n = rq; host_wdata = wd;
        loc_sel = sel; loc_rd = rd; loc_wr = wr; loc_be_n = be; loc_a1 = a1;
        loc_width = w; loc_din = din;
        #1;
        chk({req, " R6"}, "loc_dout", loc_dout, m_dout());
        @(posedge clk);
        m_step();
        #1;
        chk(req, "pend_n", {28'd0, pend_n}, {28'd0, m_pend});
        chk({req, " R9"}, "done", {31'd0, done}, {31'd0, (m_state == 3)});
        chk(req, "host_rdata", host_rdata, m_word());
        @(negedge clk);
    endtask

    task automatic idle(string req, int n);
        for (int i = 0; i < n; i++) cyc(req, 0, 0, 4'hF, 0, 0, 0, 0, 4'hF, 0, 2'd0, 0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #12;
        // R1: reset state
        chk("R1", "pend_n", {28'd0, pend_n}, 32'hF);
        chk("R1", "done", {31'd0, done}, 0);
        chk("R1", "host_rdata", host_rdata, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R5 R7: drain in 32-bit mode
        cyc("R2", 1, 0, 4'h0, 32'hA1B2C3D4, 0, 0, 0, 4'hF, 0, 2'd2, 0);
        cyc("R10", 0, 0, 4'hF, 0, 0, 1, 0, 4'h0, 0, 2'd2, 0);
        cyc("R7 R5", 0, 0, 4'hF, 0, 1, 1, 0, 4'hC, 0, 2'd2, 0);
        cyc("R7 R5", 0, 0, 4'hF, 0, 1, 1, 0, 4'h3, 0, 2'd3, 0);
        idle("R9", 3);

        // R3 R7: drain in 8-bit mode, two bytes requested
        cyc("R2", 1, 0, 4'hA, 32'h11223344, 0, 0, 0, 4'hF, 0, 2'd0, 0);
        cyc("R10", 0, 0, 4'hF, 0, 1, 1, 1, 4'hA, 0, 2'd0, 0);
        cyc("R10", 0, 0, 4'hF, 0, 1, 0, 1, 4'hB, 0, 2'd0, 32'hFF);
        cyc("R7 R3", 0, 0, 4'hF, 0, 1, 1, 0, 4'hB, 0, 2'd0, 0);
        cyc("R7 R3", 0, 0, 4'hF, 0, 1, 1, 0, 4'hE, 0, 2'd0, 0);
        idle("R9", 2);

        // R4 R8: fill in 16-bit mode, both halves
        cyc("R2", 1, 1, 4'h0, 32'h0, 0, 0, 0, 4'hF, 0, 2'd1, 0);
        cyc("R10", 0, 0, 4'hF, 0, 1, 0, 1, 4'h3, 0, 2'd1, 32'h9999);
        cyc("R8 R4", 0, 0, 4'hF, 0, 1, 0, 1, 4'hC, 0, 2'd1, 32'h1234);
        cyc("R8 R4", 0, 0, 4'hF, 0, 1, 0, 1, 4'h3, 1, 2'd1, 32'h5678);
        cyc("R6 R4", 0, 0, 4'hF, 0, 1, 1, 0, 4'h0, 1, 2'd1, 0);
        idle("R9", 2);
        cyc("R10", 0, 0, 4'hF, 0, 1, 0, 1, 4'h0, 0, 2'd2, 32'hDEADBEEF);

        // R3 R8: fill in 8-bit mode a byte at a time, load meets a strobe
        cyc("R2", 1, 1, 4'h5, 32'h0, 0, 0, 0, 4'hF, 0, 2'd0, 0);
        cyc("R8 R3", 0, 0, 4'hF, 0, 1, 0, 1, 4'hD, 0, 2'd0, 32'hAB);
        cyc("R2", 1, 1, 4'h0, 32'h0, 1, 0, 1, 4'h0, 0, 2'd2, 32'hFFFFFFFF);
        for (int k = 0; k < 4; k++)
            cyc("R8 R3", 0, 0, 4'hF, 0, 1, 0, 1, ~(4'b1 << k), 0, 2'd0, 32'h10 + k);
        idle("R9", 2);

        // Randomized run against the model
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r = $urandom;
            cyc("R2-mix", (r[2:0] == 0), r[3], 4'($urandom), $urandom,
                r[4] | r[5], r[6], r[7] & r[8], 4'($urandom), r[9], 2'(r[11:10]), $urandom);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule